// File: doc/BRIEF.md
# Prescaled Interval and PWM Timer

This block is a single timer channel. The system clock passes through two scaling stages before it reaches the counter. The first stage is an 8-bit prescaler that divides by (value + 1). The second stage is a power-of-two divider selected by a 4-bit code. Each resulting tick decrements a down-counter. The tick that finds the counter at zero is an expiry, and each expiry pulses an interrupt. The counter's start value and the PWM threshold sit in two software-written buffer registers. They reach the active counter and comparator only through an explicit load strobe, or at an expiry in auto-reload mode. Because of this, software can stage the next period without disturbing the current one.

Two operating styles are available. Auto-reload mode makes a free-running periodic timer; its live count can be sampled at any moment to time a delay to within one tick. One-shot mode stops at zero after a single expiry. The PWM output compares the live count against the active threshold, and an invert input flips its polarity.

Top module: `ptmr_top`

## Requirements
- R1: After reset, count_obs_o is 0, irq_o is 0, pwm_o is 0, and reg_rdata (address 0 selected) is 0.
- R2: Writes are decoded by address: 0 is the prescaler (wdata[7:0]), 1 is the divider code (wdata[3:0]), 2 is the count buffer, and 3 is the compare buffer. reg_rdata shows the zero-extended register selected by reg_addr at the previous clock edge.
- R3: While start_i is high, one tick occurs every (prescaler+1)*ratio clocks. While start_i is low, both scaling stages return to zero and the counter holds its value.
- R4: Divider codes 0,1,2,3,4 select ratios 1,2,4,8,16. Every code from 5 to 15 selects 16.
- R5: A manual_update_i cycle copies the count buffer into the counter and the compare buffer into the active threshold. It also re-arms a stopped one-shot, and it takes priority over a tick in the same cycle.
- R6: Each tick on a nonzero count lowers it by one, and count_obs_o always shows the live count.
- R7: A tick that finds the count at 0 is an expiry, and irq_o is high for the one clock after it.
- R8: In auto-reload mode an expiry reloads the counter and threshold from the buffers. The interrupt period is then (prescaler+1)*ratio*(count buffer+1) clocks.
- R9: In one-shot mode (auto_reload_i low) an expiry leaves the count at 0. No further interrupt occurs until manual_update_i.
- R10: pwm_o is registered. While start_i is high and no one-shot has finished, it equals (count <= threshold) XOR invert_i. Otherwise it equals invert_i.
- R11: Writing a buffer while the timer runs has no effect on the current period. The new value applies only at the next reload or manual update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Registered read data |
| start_i | input | 1 | Run enable |
| auto_reload_i | input | 1 | 1 = periodic, 0 = one-shot |
| invert_i | input | 1 | PWM polarity flip |
| manual_update_i | input | 1 | Load buffers into active registers |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | One-clock expiry pulse |
| count_obs_o | output | CNT_W | Live counter value |

## Verification
The bench measures interrupt spacing under several prescaler and divider settings. It includes an out-of-range divider code, which a design that decodes only five values would turn into a wrong or zero ratio. It rewrites the count buffer in mid-period. An unbuffered design would shorten or stretch the period already under way instead of the next one. The one-shot run checks that the interrupt fires once and the count parks at zero; a design that keeps counting would wrap and fire again. A cycle model compares the count, interrupt, PWM level and read data on every clock, including invert changes and manual loads held across ticks.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int PRE_W   = 8;
  localparam int DCODE_W = 4;
  localparam int DIV_CW  = 4;  // holds ratio-1 for ratios up to 16

  typedef enum logic [1:0] {
    RA_PRESCALE = 2'd0,
    RA_DIVCODE  = 2'd1,
    RA_CNTBUF   = 2'd2,
    RA_CMPBUF   = 2'd3
  } ptmr_addr_e;

  // last value of the divider stage counter for a given code
  function automatic logic [DIV_CW-1:0] div_last(input logic [DCODE_W-1:0] code);
    logic [DIV_CW-1:0] r;
    case (code)
      4'd0:    r = 4'd0;
      4'd1:    r = 4'd1;
      4'd2:    r = 4'd3;
      4'd3:    r = 4'd7;
      default: r = 4'd15;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptmr_reg_file.sv
module ptmr_reg_file
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [CNT_W-1:0]    wdata,
  output logic [CNT_W-1:0]    rdata,
  output logic [PRE_W-1:0]    pre_o,
  output logic [DCODE_W-1:0]  dcode_o,
  output logic [CNT_W-1:0]    cnt_buf_o,
  output logic [CNT_W-1:0]    cmp_buf_o
);
  localparam int PRE_PAD = CNT_W - PRE_W;
  localparam int DC_PAD  = CNT_W - DCODE_W;

  ptmr_addr_e sel;
  assign sel = ptmr_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_o     <= '0;
      dcode_o   <= '0;
      cnt_buf_o <= '0;
      cmp_buf_o <= '0;
    end else if (we) begin
      case (sel)
        RA_PRESCALE: pre_o     <= wdata[PRE_W-1:0];
        RA_DIVCODE:  dcode_o   <= wdata[DCODE_W-1:0];
        RA_CNTBUF:   cnt_buf_o <= wdata;
        default:     cmp_buf_o <= wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        RA_PRESCALE: rdata <= {{PRE_PAD{1'b0}}, pre_o};
        RA_DIVCODE:  rdata <= {{DC_PAD{1'b0}}, dcode_o};
        RA_CNTBUF:   rdata <= cnt_buf_o;
        default:     rdata <= cmp_buf_o;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_tick_gen.sv
module ptmr_tick_gen
  import ptmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic [PRE_W-1:0]   pre_i,
  input  logic [DCODE_W-1:0] dcode_i,
  output logic               tick_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [DIV_CW-1:0] div_q;
  logic [DIV_CW-1:0] div_end;
  logic              pre_wrap;
  logic              div_wrap;

  assign div_end  = div_last(dcode_i);
  // >= keeps the stages bounded if a setting is lowered mid-count
  assign pre_wrap = (pre_q >= pre_i);
  assign div_wrap = (div_q >= div_end);
  assign tick_o   = run_i && pre_wrap && div_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (pre_wrap) div_q <= div_wrap ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_count_core.sv
module ptmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             auto_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             done_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic at_zero;
  logic expire;

  assign at_zero = (cnt_o == '0);
  assign expire  = tick_i && !done_o && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      cmp_o  <= '0;
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else if (load_i) begin
      cnt_o  <= cnt_buf_i;
      cmp_o  <= cmp_buf_i;
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= expire;
      if (expire) begin
        if (auto_i) begin
          cnt_o <= cnt_buf_i;
          cmp_o <= cmp_buf_i;
        end else begin
          done_o <= 1'b1;
        end
      end else if (tick_i && !done_o) begin
        cnt_o <= cnt_o - ONE;
      end
    end
  end
endmodule

// File: rtl/ptmr_wave_out.sv
module ptmr_wave_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             invert_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o
);
  logic level;
  assign level = active_i ? (cnt_i <= cmp_i) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= level ^ invert_i;
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             start_i,
  input  logic             auto_reload_i,
  input  logic             invert_i,
  input  logic             manual_update_i,
  output logic             pwm_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] count_obs_o
);
  logic [PRE_W-1:0]   pre_val;
  logic [DCODE_W-1:0] dcode;
  logic [CNT_W-1:0]   cnt_buf;
  logic [CNT_W-1:0]   cmp_buf;
  logic [CNT_W-1:0]   cmp_act;
  logic               tick;
  logic               done;

  ptmr_reg_file #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pre_o(pre_val), .dcode_o(dcode),
    .cnt_buf_o(cnt_buf), .cmp_buf_o(cmp_buf)
  );

  ptmr_tick_gen tick_i (
    .clk(clk), .rst(rst), .run_i(start_i), .pre_i(pre_val),
    .dcode_i(dcode), .tick_o(tick)
  );

  ptmr_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .tick_i(tick), .load_i(manual_update_i),
    .auto_i(auto_reload_i), .cnt_buf_i(cnt_buf), .cmp_buf_i(cmp_buf),
    .cnt_o(count_obs_o), .cmp_o(cmp_act), .done_o(done), .irq_o(irq_o)
  );

  ptmr_wave_out #(.CNT_W(CNT_W)) wave_i (
    .clk(clk), .rst(rst), .active_i(start_i && !done), .invert_i(invert_i),
    .cnt_i(count_obs_o), .cmp_i(cmp_act), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/ptmr_top_chk.sv
module ptmr_top_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             auto_reload_i,
  input logic             invert_i,
  input logic             manual_update_i,
  input logic             pwm_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_obs_o,
  input logic [CNT_W-1:0] cnt_buf
);
  AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(count_obs_o) == '0); // R7

  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !$past(auto_reload_i)) |-> count_obs_o == '0); // R9

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!$past(start_i) && !$past(manual_update_i)) |-> $stable(count_obs_o)); // R3

  AST_PWM_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !$past(start_i) |-> pwm_o == $past(invert_i)); // R10

  AST_MANUAL_LOADS: assert property (@(posedge clk) disable iff (rst)
    $past(manual_update_i) |-> count_obs_o == $past(cnt_buf)); // R5
endmodule

bind ptmr_top ptmr_top_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .auto_reload_i(auto_reload_i),
  .invert_i(invert_i), .manual_update_i(manual_update_i), .pwm_o(pwm_o),
  .irq_o(irq_o), .count_obs_o(count_obs_o), .cnt_buf(cnt_buf)
);

// File: tb/ptmr_top_tb_top.sv
`timescale 1ns/1ps
module ptmr_top_tb_top;
  localparam int CNT_W = 16;

  logic clk = 0;
  logic rst = 1;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [CNT_W-1:0] reg_wdata = 0;
  logic [CNT_W-1:0] reg_rdata;
  logic start_i = 0, auto_reload_i = 0, invert_i = 0, manual_update_i = 0;
  logic pwm_o, irq_o;
  logic [CNT_W-1:0] count_obs_o;

  int n_chk = 0, n_err = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ptmr_top #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---- behavioural reference model ----
  int m_pre, m_dc, m_cbuf, m_mbuf, m_rd;
  int m_pc, m_dv, m_cnt, m_cmp, m_irq, m_pwm;
  bit m_done;

  function automatic int ratio(input int code);
    return (code < 5) ? (1 << code) : 16;
  endfunction

  always @(posedge clk) begin
    int tick, nrd, npwm;
    cyc++;
    #1;
    if (rst) begin
      m_pre = 0; m_dc = 0; m_cbuf = 0; m_mbuf = 0; m_rd = 0;
      m_pc = 0; m_dv = 0; m_cnt = 0; m_cmp = 0; m_irq = 0; m_pwm = 0; m_done = 0;
    end else begin
      tick = (start_i && m_pc >= m_pre && m_dv >= ratio(m_dc) - 1) ? 1 : 0;
      npwm = ((start_i && !m_done) ? (m_cnt <= m_cmp) : 0) ^ invert_i;
      case (reg_addr)
        0: nrd = m_pre; 1: nrd = m_dc; 2: nrd = m_cbuf; default: nrd = m_mbuf;
      endcase
      if (!start_i) begin m_pc = 0; m_dv = 0; end
      else begin
        if (m_pc >= m_pre) begin
          m_dv = (m_dv >= ratio(m_dc) - 1) ? 0 : m_dv + 1;
          m_pc = 0;
        end else m_pc++;
      end
      if (manual_update_i) begin
        m_cnt = m_cbuf; m_cmp = m_mbuf; m_done = 0; m_irq = 0;
      end else begin
        m_irq = 0;
        if (tick && !m_done) begin
          if (m_cnt == 0) begin
            m_irq = 1;
            if (auto_reload_i) begin m_cnt = m_cbuf; m_cmp = m_mbuf; end
            else m_done = 1;
          end else m_cnt--;
        end
      end
      if (reg_we) begin
        case (reg_addr)
          0: m_pre = reg_wdata & 8'hFF; 1: m_dc = reg_wdata & 4'hF;
          2: m_cbuf = reg_wdata; default: m_mbuf = reg_wdata;
        endcase
      end
      m_rd = nrd; m_pwm = npwm;
    end
    chk(count_obs_o == m_cnt, "R6 count", count_obs_o, m_cnt);
    chk(irq_o == m_irq, "R7 irq", irq_o, m_irq);
    chk(pwm_o == m_pwm, "R10 pwm", pwm_o, m_pwm);
    chk(reg_rdata == m_rd, "R2 rdata", reg_rdata, m_rd);
  end

  // ---- stimulus helpers ----
  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = a[1:0]; reg_wdata = d[CNT_W-1:0];
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input int a, input int exp);
    @(negedge clk); reg_addr = a[1:0];
    @(negedge clk);
    chk(reg_rdata == exp[CNT_W-1:0], "R2 readback", reg_rdata, exp);
  endtask

  task automatic pulse_manual();
    @(negedge clk); manual_update_i = 1;
    @(negedge clk); manual_update_i = 0;
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #2;
      if (irq_o) begin at = cyc; break; end
    end
  endtask

  task automatic setup(input int pre, input int dc, input int cb, input int mb);
    @(negedge clk); start_i = 0;
    wr(0, pre); wr(1, dc); wr(2, cb); wr(3, mb);
    pulse_manual();
    @(negedge clk); start_i = 1;
  endtask

  task automatic gap_chk(input string tag, input int exp);
    int a, b;
    wait_irq(a); wait_irq(b);
    chk(a >= 0 && b >= 0 && (b - a) == exp, tag, b - a, exp);
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int a, b, c, n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(count_obs_o == 0, "R1 count", count_obs_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    chk(pwm_o == 0, "R1 pwm", pwm_o, 0);
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);

    wr(0, 16'h1F2); wr(1, 16'h3A); wr(2, 4); wr(3, 2);
    rd_chk(0, 8'hF2); rd_chk(1, 4'hA); rd_chk(2, 4); rd_chk(3, 2);

    // R8/R3: prescale 2, ratio 2, period 5 ticks -> 30 clocks
    auto_reload_i = 1;
    setup(2, 1, 4, 2);
    gap_chk("R8 period pre2 div2", 30);

    // R11: rewrite count buffer mid-period; current period keeps 30
    wait_irq(a);
    wr(2, 6);
    wait_irq(b);
    chk(b - a == 30, "R11 current period kept", b - a, 30);
    wait_irq(c);
    chk(c - b == 42, "R11 new period after reload", c - b, 42);

    // R10: invert while running
    @(negedge clk); invert_i = 1;
    repeat (60) @(negedge clk);
    invert_i = 0;

    // R4: out-of-range code 9 -> ratio 16; code 3 -> 8
    setup(0, 9, 1, 0);
    gap_chk("R4 code9 ratio16", 32);
    setup(0, 3, 1, 1);
    gap_chk("R4 code3 ratio8", 16);
    setup(1, 0, 2, 1);
    gap_chk("R3 pre1 ratio1", 6);

    // R3: stop holds the count
    @(negedge clk); start_i = 0;
    a = count_obs_o;
    repeat (20) @(negedge clk);
    chk(count_obs_o == a, "R3 hold when stopped", count_obs_o, a);
    chk(pwm_o == 0, "R10 idle level", pwm_o, 0);

    // R9: one-shot fires once and parks at zero
    auto_reload_i = 0;
    setup(0, 0, 3, 1);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #2; if (irq_o) n++;
    end
    chk(n == 1, "R9 single irq", n, 1);
    chk(count_obs_o == 0, "R9 parked at zero", count_obs_o, 0);
    @(negedge clk); invert_i = 1;
    @(negedge clk); @(negedge clk);
    chk(pwm_o == 1, "R10 done level follows invert", pwm_o, 1);
    invert_i = 0;

    // R5: manual re-arms, and holds priority over ticks
    pulse_manual();
    chk(count_obs_o == 3, "R5 reload by manual", count_obs_o, 3);
    wait_irq(a);
    chk(a >= 0, "R5 re-armed one-shot fires", a, 1);
    @(negedge clk); manual_update_i = 1;
    repeat (10) @(negedge clk);
    chk(count_obs_o == 3, "R5 manual beats tick", count_obs_o, 3);
    manual_update_i = 0;
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule